// File: doc/BRIEF.md
# Multi-latency issue and writeback arbiter

This block sits at the issue stage of a single-issue, in-order pipeline. The pipeline feeds four functional units into one shared writeback stage: an integer unit, a pipelined adder, a pipelined multiplier and an unpipelined divider. Each unit takes a different number of cycles. In every cycle the front end presents at most one candidate instruction, giving its unit code and its destination register. The arbiter answers in the same cycle with an issue strobe or a stall.

The arbiter stalls for three reasons. The first is that the result would reach writeback in a cycle already claimed by another result. The second is that the divider is still working on its previous operation. The third is that the result would reach writeback no later than an older write to the same register that is still pending. Writeback cycles are claimed at issue time in a slot ring that shifts every cycle. Each architectural register has a countdown to its last pending write. The arbiter also produces the writeback strobe and destination number, so the shared write port follows directly from the slot ring.

A stalled candidate is held by the front end and is evaluated again every cycle. No other instruction passes it.

Top module: `issue_wb_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, no writeback is reported. Reset leaves no reservation, no pending register write and no busy divider, so a divide offered in the first cycle after reset issues at once.
- R2: `issue` is a combinational function of the current inputs and state. It is 1 exactly when `req_valid` is 1 and no hazard from R4, R5 or R6 applies. With `req_valid` at 0, `issue` is 0.
- R3: Unit codes are 0 integer (latency 0), 1 adder (latency 3), 2 multiplier (latency 7) and 3 divider (latency 25). An instruction issued in cycle c produces `wb_valid`=1 with `wb_dest` equal to its destination in cycle c+L+1, where L is its unit's latency.
- R4: A candidate stalls if another issued instruction already writes back in cycle c+L+1. At most one writeback occurs in any cycle.
- R5: A candidate stalls if an issued, not yet written-back instruction with the same destination writes back in a cycle at or after c+L+1. A write that occurs in the current cycle does not block.
- R6: If a divide issued in cycle d, then no divide issues before cycle d+26. A divide offered in cycle d+26 is not blocked by the divider.
- R7: A held candidate issues in the first cycle in which none of the R4, R5 and R6 hazards applies to it. Later candidates never issue ahead of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A candidate instruction is present |
| req_unit | input | 2 | Unit code of the candidate (0 int, 1 add, 2 mul, 3 div) |
| req_dest | input | 5 | Destination register of the candidate |
| issue | output | 1 | Candidate issues this cycle |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_dest | output | 5 | Register written back this cycle |

## Verification
The hardest situation to reach is two hazards overlapping. One example is an adder result that would land on a slot already taken while an older multiplier write to the same register is still pending. Another is a divide that waits on the busy divider and then also finds its writeback slot taken. Directed sequences place the colliding instructions at exact cycle offsets, with idle gaps between them. A long random stream then uses only eight destination registers and many back-to-back divides, so register reuse and slot collisions happen very often. A behavioural model of per-cycle writeback claims is compared with the design in every cycle.

// File: rtl/iwa_pkg.sv
package iwa_pkg;
  typedef enum logic [1:0] {
    U_INT = 2'd0,
    U_ADD = 2'd1,
    U_MUL = 2'd2,
    U_DIV = 2'd3
  } unit_e;
endpackage

// File: rtl/iwa_slot_ring.sv
module iwa_slot_ring #(
  parameter int DEPTH = 26,
  parameter int LW    = 5,
  parameter int DW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put,
  input  logic [LW-1:0] put_lat,
  input  logic [DW-1:0] put_dest,
  input  logic [LW-1:0] query_lat,
  output logic          conflict,
  output logic          wb_valid,
  output logic [DW-1:0] wb_dest
);
  logic [DEPTH-1:0] v_q, v_d;
  logic [DW-1:0]    dst_q [DEPTH];
  logic [DW-1:0]    dst_d [DEPTH];

  // slot i holds the writeback of cycle now+i; a new entry lands at lat after shift
  always_comb begin
    conflict = 1'b0;
    for (int i = 1; i < DEPTH; i++) begin
      if (v_q[i] && (query_lat == LW'(i - 1))) conflict = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH - 1; i++) begin
      v_d[i]   = v_q[i+1];
      dst_d[i] = dst_q[i+1];
    end
    v_d[DEPTH-1]   = 1'b0;
    dst_d[DEPTH-1] = '0;
    if (put) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (put_lat == LW'(i)) begin
          v_d[i]   = 1'b1;
          dst_d[i] = put_dest;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < DEPTH; i++) dst_q[i] <= '0;
    end else begin
      v_q <= v_d;
      for (int i = 0; i < DEPTH; i++) dst_q[i] <= dst_d[i];
    end
  end

  assign wb_valid = v_q[0];
  assign wb_dest  = dst_q[0];

  // R4: a claimed slot one step from the head must reach writeback next cycle
  a_r4_slot_reaches_wb: assert property (@(posedge clk) disable iff (!rst_n)
    v_q[1] |=> wb_valid);
endmodule

// File: rtl/iwa_dest_timers.sv
module iwa_dest_timers #(
  parameter int NREG = 32,
  parameter int TW   = 5,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic [RW-1:0]   set_dest,
  input  logic [TW-1:0]   set_val,
  input  logic [RW-1:0]   query_dest,
  input  logic [TW-1:0]   query_min,
  output logic            waw,
  output logic [NREG-1:0] pending
);
  logic [TW-1:0] cnt_q [NREG];
  logic [TW-1:0] cnt_d [NREG];

  // count n means the latest write to that register lands n-1 cycles from now
  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      cnt_d[k] = (cnt_q[k] != '0) ? cnt_q[k] - 1'b1 : '0;
      if (set && (set_dest == RW'(k))) cnt_d[k] = set_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) cnt_q[k] <= '0;
    end else begin
      for (int k = 0; k < NREG; k++) cnt_q[k] <= cnt_d[k];
    end
  end

  assign waw = (cnt_q[query_dest] >= query_min);

  for (genvar g = 0; g < NREG; g++) begin : g_pend
    assign pending[g] = (cnt_q[g] != '0);
  end
endmodule

// File: rtl/iwa_div_busy.sv
module iwa_div_busy #(
  parameter int LAT = 25,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    if (start)       cnt_d = CW'(LAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R6: once running, the divider counts down one per cycle with no restart
  a_r6_div_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/issue_wb_arbiter.sv
module issue_wb_arbiter
  import iwa_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int LAT_INT = 0,
  parameter int LAT_ADD = 3,
  parameter int LAT_MUL = 7,
  parameter int LAT_DIV = 25,
  localparam int RW     = $clog2(NREG),
  localparam int TW     = $clog2(LAT_DIV + 3),
  localparam int DEPTH  = LAT_DIV + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_unit,
  input  logic [RW-1:0] req_dest,
  output logic          issue,
  output logic          wb_valid,
  output logic [RW-1:0] wb_dest
);
  unit_e            unit;
  logic [TW-1:0]    lat;
  logic             slot_hit, waw_hit, div_busy, stall;
  logic [NREG-1:0]  pending;

  assign unit = unit_e'(req_unit);

  always_comb begin
    case (unit)
      U_INT:   lat = TW'(LAT_INT);
      U_ADD:   lat = TW'(LAT_ADD);
      U_MUL:   lat = TW'(LAT_MUL);
      default: lat = TW'(LAT_DIV);
    endcase
  end

  assign stall = slot_hit | waw_hit | (div_busy && (unit == U_DIV));
  assign issue = req_valid & ~stall;

  iwa_slot_ring #(.DEPTH(DEPTH), .LW(TW), .DW(RW)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .put(issue), .put_lat(lat), .put_dest(req_dest),
    .query_lat(lat), .conflict(slot_hit),
    .wb_valid(wb_valid), .wb_dest(wb_dest)
  );

  iwa_dest_timers #(.NREG(NREG), .TW(TW)) u_timers (
    .clk(clk), .rst_n(rst_n),
    .set(issue), .set_dest(req_dest), .set_val(lat + TW'(1)),
    .query_dest(req_dest), .query_min(lat + TW'(2)),
    .waw(waw_hit), .pending(pending)
  );

  iwa_div_busy #(.LAT(LAT_DIV)) u_div (
    .clk(clk), .rst_n(rst_n),
    .start(issue && (unit == U_DIV)),
    .busy(div_busy)
  );

  // R3: an integer operation reaches writeback in the very next cycle
  a_r3_int_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (unit == U_INT)) |=> (wb_valid && (wb_dest == $past(req_dest))));

  // R5: the slot ring and the register timers agree on every writeback
  a_r5_wb_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> pending[wb_dest]);

  // R2: nothing issues without a candidate
  a_r2_issue_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> req_valid);
endmodule

// File: tb/tb_issue_wb_arbiter.sv
module tb_issue_wb_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n, req_valid, issue, wb_valid;
  logic [1:0] req_unit;
  logic [4:0] req_dest, wb_dest;

  int checks, errors;
  int q_u[$], q_d[$];
  int sched[int];
  int last_wb[32];
  int div_free;
  bit done;

  issue_wb_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_unit(req_unit),
    .req_dest(req_dest), .issue(issue), .wb_valid(wb_valid), .wb_dest(wb_dest)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int lat_of(int u);
    case (u)
      0: return 0;
      1: return 3;
      2: return 7;
      default: return 25;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(int u, int d);
    q_u.push_back(u);
    q_d.push_back(d);
  endtask

  task automatic check_wb(int cyc);
    bit ev;
    ev = sched.exists(cyc);
    check(wb_valid == ev, "R3", "wb_valid", int'(wb_valid), int'(ev));
    if (ev && wb_valid) check(int'(wb_dest) == sched[cyc], "R3", "wb_dest", int'(wb_dest), sched[cyc]);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc, qi, u, d, t;
    bit held, coll, waw, divb, exp_iss;
    string tag;
    checks = 0; errors = 0; done = 0;
    for (int r = 0; r < 32; r++) last_wb[r] = -1;
    div_free = 0;

    // directed part
    push(3, 2);            // R1: divide right after reset issues at once
    push(3, 3);            // R6: second divide waits for the divider
    push(0, 1);
    push(2, 4); push(1, 4);                      // R5: add overtaking mul to r4
    push(-1, 0);
    push(1, 5); push(-1, 0); push(-1, 0); push(0, 6);  // R4: int lands on add slot
    push(2, 7); push(0, 7);                      // R5: int overtaking mul to r7
    push(0, 7);                                  // R7: held behind the previous one
    push(3, 9); push(1, 9);
    // random part
    for (int n = 0; n < 700; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 2)       push(-1, 0);
      else if (r < 4)  push(0, int'($urandom_range(0, 7)));
      else if (r < 6)  push(1, int'($urandom_range(0, 7)));
      else if (r < 8)  push(2, int'($urandom_range(0, 7)));
      else             push(3, int'($urandom_range(0, 7)));
    end

    rst_n = 1'b0; req_valid = 1'b0; req_unit = '0; req_dest = '0;
    repeat (3) @(posedge clk);
    #1;
    check(wb_valid == 1'b0, "R1", "wb_valid in reset", int'(wb_valid), 0);
    check(issue == 1'b0, "R2", "issue with no candidate", int'(issue), 0);
    @(negedge clk);
    rst_n = 1'b1;

    cyc = 0; qi = 0; held = 0;
    while (qi < q_u.size()) begin
      @(negedge clk);
      check_wb(cyc);
      u = q_u[qi]; d = q_d[qi];
      if (u < 0) req_valid = 1'b0;
      else begin
        req_valid = 1'b1; req_unit = 2'(u); req_dest = 5'(d);
      end
      #1;
      if (u < 0) begin
        check(issue == 1'b0, "R2", "issue on idle cycle", int'(issue), 0);
        qi++;
        held = 0;
      end else begin
        t = cyc + lat_of(u) + 1;
        coll = sched.exists(t);
        waw = (last_wb[d] >= t);
        divb = (u == 3) && (cyc < div_free);
        exp_iss = !(coll || waw || divb);
        if (divb) tag = "R6";
        else if (waw) tag = "R5";
        else if (coll) tag = "R4";
        else if (cyc == 0) tag = "R1";
        else if (held) tag = "R7";
        else tag = "R2";
        check(issue == exp_iss, tag, "issue", int'(issue), int'(exp_iss));
        if (exp_iss) begin
          sched[t] = d;
          last_wb[d] = t;
          if (u == 3) div_free = cyc + 26;
          qi++;
          held = 0;
        end else held = 1;
      end
      @(posedge clk);
      cyc++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) begin
      check_wb(cyc);
      #1;
      check(issue == 1'b0, "R2", "issue after stream", int'(issue), 0);
      @(negedge clk);
      cyc++;
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule